// File: doc/BRIEF.md
# Reset Boot Mode Sequencer

This block starts a small processor after a master reset. While reset is held it reads four strap pins, A, B, C and D. Pin C is the programmable flag 2 pin. It turns the straps into a boot method, a memory configuration and an acknowledge drive style. Once reset is released it does one of three things:

- It pulls a fixed block of program words from a byte-wide memory through a request/acknowledge DMA port.
- It waits for a host to write internal program address 0.
- It releases the core at once, starting from external memory.

Until the chosen sequence finishes, the core is kept stalled. It is then released with a one-cycle pulse, a start address and a flag telling whether that address is external. While the sequencer is in its reset state, it asks the core to empty its stacks, mask all interrupts and clear its mode/status register.

A bus request that is pending when reset is released defers a boot until the request is withdrawn. The bus is never granted while the byte DMA is fetching.

Top module: `boot_seq`

## Requirements
- R1: While rst_ni is low: core_init_o=1, core_stall_o=1, core_release_o=0 and flag2_o=0.
- R2: The straps are captured during reset, up to and including the first clock edge after release. Only the code {C,B,A} picks the boot method:
  - 000 selects byte boot with host_mode_o=0.
  - 010 selects no boot with host_mode_o=0.
  - 100 selects byte boot with host_mode_o=1.
  - 101 selects host boot with host_mode_o=1.
  - Every other code selects no boot with host_mode_o=0 and mode_err_o=1. mode_err_o=0 for the four listed codes.
- R3: Once out of reset, flag2_o follows pf2_pin_i, and changes on that pin do not alter the captured mode.
- R4: In no-boot modes, core_release_o pulses on the first clock edge after reset release, whatever bus_req_i is. It comes with start_ext_o=1 and start_addr_o=0.
- R5: A byte boot fetches byte addresses 0,1,2,… in order on bdma_addr_o, one per acknowledged request. Each group of three bytes forms one 24-bit word, first byte most significant. Word k is written with pm_we_o to pm_addr_o=k.
- R6: A byte boot writes exactly 32 words. core_release_o pulses in the same cycle as the 32nd write, with start_ext_o=0 and start_addr_o=0. core_stall_o stays 1 until then.
- R7: A host boot releases the core, with start_ext_o=0, one cycle after host_pm_we_i is seen with host_pm_addr_i=0. Host writes to any other address have no effect on stall or release.
- R8: If bus_req_i is high when reset is released in a boot mode, no boot starts and bus_grant_o=1 until the request falls. bus_grant_o is never 1 while bdma_req_o is 1.
- R9: ack_push_pull_o = host mode and D=0. ack_open_drain_o = host mode and D=1. Both are 0 outside host mode.
- R10: core_release_o is a single-cycle pulse that occurs once per reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| mode_a_i | input | 1 | Strap A |
| mode_b_i | input | 1 | Strap B |
| mode_d_i | input | 1 | Strap D (acknowledge drive style) |
| pf2_pin_i | input | 1 | Shared strap C / flag 2 pin |
| flag2_o | output | 1 | Flag 2 input value after reset |
| bus_req_i | input | 1 | External bus request |
| bus_grant_o | output | 1 | Bus grant |
| bdma_req_o | output | 1 | Byte DMA request |
| bdma_addr_o | output | BYTE_AW | Byte memory address |
| bdma_ack_i | input | 1 | Byte DMA acknowledge, data valid |
| bdma_data_i | input | 8 | Byte read data |
| pm_we_o | output | 1 | Program memory write strobe |
| pm_addr_o | output | PM_AW | Program memory word address |
| pm_wdata_o | output | 24 | Program word |
| host_pm_we_i | input | 1 | Host program memory write seen |
| host_pm_addr_i | input | PM_AW | Host write address |
| core_init_o | output | 1 | Empty stacks, mask interrupts, clear status |
| core_stall_o | output | 1 | Core held |
| core_release_o | output | 1 | Release pulse |
| start_addr_o | output | PM_AW | First fetch address |
| start_ext_o | output | 1 | Start address is in external memory |
| host_mode_o | output | 1 | Host mode configuration |
| mode_err_o | output | 1 | Unlisted strap code |
| ack_push_pull_o | output | 1 | Acknowledge actively driven |
| ack_open_drain_o | output | 1 | Acknowledge needs external pull-down |

## Verification
The bench sweeps all sixteen strap codes, and for several of them it holds a bus request across reset release.

- A decoder that lets strap D leak into the boot choice would show up as the wrong host_mode_o or mode_err_o.
- A word counter that is off by one would release one word early or late, or skip the last word.
- A byte assembler with its lanes swapped would write words whose bytes come out in the wrong order.
- A sequencer that ignores the host address would release on the write to address 5.
- A sequencer that ignores the bus request would raise bdma_req_o while the grant is high, including when the request rises in the middle of a load.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [2:0] {
    ST_RESET, ST_WAIT_BUS, ST_BDMA, ST_WAIT_HOST, ST_RUN
  } seq_state_e;

  typedef enum logic [1:0] {BOOT_NONE, BOOT_BYTE, BOOT_HOST} boot_kind_e;

  typedef struct packed {
    boot_kind_e kind;
    logic       host_mode;
    logic       ack_od;
    logic       err;
  } strap_cfg_t;

  // straps: d selects ack style only; {c,b,a} selects boot
  function automatic strap_cfg_t decode_straps(logic d, logic c, logic b, logic a);
    strap_cfg_t r;
    r = '0;
    r.kind = BOOT_NONE;
    r.ack_od = d;
    case ({c, b, a})
      3'b000: r.kind = BOOT_BYTE;
      3'b010: r.kind = BOOT_NONE;
      3'b100: begin r.kind = BOOT_BYTE; r.host_mode = 1'b1; end
      3'b101: begin r.kind = BOOT_HOST; r.host_mode = 1'b1; end
      default: r.err = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/boot_strap.sv
module boot_strap
  import boot_pkg::*;
(
  input  logic       clk_i,
  input  logic       capture_i,
  input  logic       mode_a_i,
  input  logic       mode_b_i,
  input  logic       mode_d_i,
  input  logic       pf2_pin_i,
  output strap_cfg_t cfg_o,
  output logic       flag2_o
);
  logic [3:0] strap_q;

  // sampled while the sequencer sits in its reset state
  always_ff @(posedge clk_i) begin
    if (capture_i) strap_q <= {mode_d_i, pf2_pin_i, mode_b_i, mode_a_i};
  end

  assign cfg_o   = decode_straps(strap_q[3], strap_q[2], strap_q[1], strap_q[0]);
  assign flag2_o = capture_i ? 1'b0 : pf2_pin_i;
endmodule

// File: rtl/boot_bdma.sv
module boot_bdma #(
  parameter int BOOT_WORDS = 32,
  parameter int WORD_BYTES = 3,
  parameter int BYTE_AW    = 14,
  parameter int PM_AW      = 14,
  localparam int WORD_W    = 8 * WORD_BYTES,
  localparam int ACC_W     = 8 * (WORD_BYTES - 1),
  localparam int CNT_W     = $clog2(BOOT_WORDS),
  localparam int BI_W      = $clog2(WORD_BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               active_i,
  input  logic               ack_i,
  input  logic [7:0]         data_i,
  output logic               req_o,
  output logic [BYTE_AW-1:0] byte_addr_o,
  output logic               pm_we_o,
  output logic [PM_AW-1:0]   pm_addr_o,
  output logic [WORD_W-1:0]  pm_wdata_o,
  output logic               done_o
);
  logic [BI_W-1:0]    byte_idx_q;
  logic [CNT_W-1:0]   word_q;
  logic [ACC_W-1:0]   acc_q;
  logic [BYTE_AW-1:0] baddr_q;
  logic               we_q;
  logic [PM_AW-1:0]   waddr_q;
  logic [WORD_W-1:0]  wdata_q;
  logic               take, last_byte, last_word;

  assign take      = active_i & ack_i;
  assign last_byte = byte_idx_q == BI_W'(WORD_BYTES - 1);
  assign last_word = word_q == CNT_W'(BOOT_WORDS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_idx_q <= '0;
      word_q     <= '0;
      acc_q      <= '0;
      baddr_q    <= '0;
      we_q       <= 1'b0;
      waddr_q    <= '0;
      wdata_q    <= '0;
    end else begin
      we_q <= take & last_byte;
      if (take) begin
        baddr_q <= baddr_q + 1'b1;
        if (last_byte) begin
          byte_idx_q <= '0;
          wdata_q    <= {acc_q, data_i};
          waddr_q    <= PM_AW'(word_q);
          word_q     <= word_q + 1'b1;
        end else begin
          byte_idx_q <= byte_idx_q + 1'b1;
          acc_q      <= (acc_q << 8) | ACC_W'(data_i);
        end
      end
    end
  end

  assign req_o       = active_i;
  assign byte_addr_o = baddr_q;
  assign pm_we_o     = we_q;
  assign pm_addr_o   = waddr_q;
  assign pm_wdata_o  = wdata_q;
  assign done_o      = take & last_byte & last_word;
endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_pkg::*;
#(
  parameter int BOOT_WORDS = 32,
  parameter int WORD_BYTES = 3,
  parameter int BYTE_AW    = 14,
  parameter int PM_AW      = 14,
  localparam int WORD_W    = 8 * WORD_BYTES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_a_i,
  input  logic               mode_b_i,
  input  logic               mode_d_i,
  input  logic               pf2_pin_i,
  output logic               flag2_o,
  input  logic               bus_req_i,
  output logic               bus_grant_o,
  output logic               bdma_req_o,
  output logic [BYTE_AW-1:0] bdma_addr_o,
  input  logic               bdma_ack_i,
  input  logic [7:0]         bdma_data_i,
  output logic               pm_we_o,
  output logic [PM_AW-1:0]   pm_addr_o,
  output logic [WORD_W-1:0]  pm_wdata_o,
  input  logic               host_pm_we_i,
  input  logic [PM_AW-1:0]   host_pm_addr_i,
  output logic               core_init_o,
  output logic               core_stall_o,
  output logic               core_release_o,
  output logic [PM_AW-1:0]   start_addr_o,
  output logic               start_ext_o,
  output logic               host_mode_o,
  output logic               mode_err_o,
  output logic               ack_push_pull_o,
  output logic               ack_open_drain_o
);
  seq_state_e state_q, state_d, boot_st;
  strap_cfg_t cfg;
  boot_kind_e boot_kind;
  logic       release_q, fire, bdma_done, in_reset;

  assign in_reset  = state_q == ST_RESET;
  assign boot_kind = cfg.kind;

  boot_strap u_strap (
    .clk_i     (clk_i),
    .capture_i (in_reset),
    .mode_a_i  (mode_a_i),
    .mode_b_i  (mode_b_i),
    .mode_d_i  (mode_d_i),
    .pf2_pin_i (pf2_pin_i),
    .cfg_o     (cfg),
    .flag2_o   (flag2_o)
  );

  boot_bdma #(
    .BOOT_WORDS (BOOT_WORDS),
    .WORD_BYTES (WORD_BYTES),
    .BYTE_AW    (BYTE_AW),
    .PM_AW      (PM_AW)
  ) u_bdma (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (state_q == ST_BDMA),
    .ack_i       (bdma_ack_i),
    .data_i      (bdma_data_i),
    .req_o       (bdma_req_o),
    .byte_addr_o (bdma_addr_o),
    .pm_we_o     (pm_we_o),
    .pm_addr_o   (pm_addr_o),
    .pm_wdata_o  (pm_wdata_o),
    .done_o      (bdma_done)
  );

  always_comb begin
    state_d = state_q;
    fire    = 1'b0;
    boot_st = (boot_kind == BOOT_BYTE) ? ST_BDMA : ST_WAIT_HOST;
    unique case (state_q)
      ST_RESET: begin
        if (boot_kind == BOOT_NONE) begin
          state_d = ST_RUN;
          fire    = 1'b1;
        end else if (bus_req_i) begin
          state_d = ST_WAIT_BUS;
        end else begin
          state_d = boot_st;
        end
      end
      ST_WAIT_BUS:  if (!bus_req_i) state_d = boot_st;
      ST_BDMA: begin
        if (bdma_done) begin
          state_d = ST_RUN;
          fire    = 1'b1;
        end
      end
      ST_WAIT_HOST: begin
        if (host_pm_we_i && host_pm_addr_i == '0) begin
          state_d = ST_RUN;
          fire    = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RESET;
      release_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      release_q <= fire;
    end
  end

  assign core_init_o      = in_reset;
  assign core_stall_o     = state_q != ST_RUN;
  assign core_release_o   = release_q;
  assign start_addr_o     = '0;
  assign start_ext_o      = boot_kind == BOOT_NONE;
  assign bus_grant_o      = bus_req_i & ~in_reset & (state_q != ST_BDMA);
  assign host_mode_o      = cfg.host_mode;
  assign mode_err_o       = cfg.err;
  assign ack_push_pull_o  = cfg.host_mode & ~cfg.ack_od;
  assign ack_open_drain_o = cfg.host_mode & cfg.ack_od;
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk
  import boot_pkg::*;
#(
  parameter int BOOT_WORDS = 32,
  parameter int BYTE_AW    = 14,
  parameter int PM_AW      = 14
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               core_release_o,
  input logic               core_stall_o,
  input logic               bus_grant_o,
  input logic               bdma_req_o,
  input logic               bdma_ack_i,
  input logic [BYTE_AW-1:0] bdma_addr_o,
  input logic               pm_we_o,
  input logic               host_pm_we_i,
  input logic [PM_AW-1:0]   host_pm_addr_i,
  input logic               host_mode_o,
  input logic               mode_err_o,
  input logic               ack_push_pull_o,
  input logic               ack_open_drain_o,
  input boot_kind_e         boot_kind
);
  logic [15:0] words_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) words_q <= '0;
    else if (pm_we_o) words_q <= words_q + 1'b1;
  end

  // R10
  release_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_release_o |=> !core_release_o);
  // R6
  stall_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_stall_o) |-> core_release_o);
  // R6
  word_total_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_release_o && boot_kind == BOOT_BYTE) |-> (pm_we_o && words_q == 16'(BOOT_WORDS - 1)));
  // R7
  host_pm0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_release_o && boot_kind == BOOT_HOST) |-> $past(host_pm_we_i && host_pm_addr_i == '0));
  // R8
  grant_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_grant_o |-> !bdma_req_o);
  // R5
  byte_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bdma_req_o && bdma_ack_i) |=> bdma_addr_o == $past(bdma_addr_o) + 1'b1);
  // R9
  ack_style_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_push_pull_o || ack_open_drain_o) |-> (host_mode_o && !(ack_push_pull_o && ack_open_drain_o)));
  // R2
  mode_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> (!host_mode_o && boot_kind == BOOT_NONE));
endmodule

bind boot_seq boot_seq_chk #(
  .BOOT_WORDS (BOOT_WORDS),
  .BYTE_AW    (BYTE_AW),
  .PM_AW      (PM_AW)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .core_release_o   (core_release_o),
  .core_stall_o     (core_stall_o),
  .bus_grant_o      (bus_grant_o),
  .bdma_req_o       (bdma_req_o),
  .bdma_ack_i       (bdma_ack_i),
  .bdma_addr_o      (bdma_addr_o),
  .pm_we_o          (pm_we_o),
  .host_pm_we_i     (host_pm_we_i),
  .host_pm_addr_i   (host_pm_addr_i),
  .host_mode_o      (host_mode_o),
  .mode_err_o       (mode_err_o),
  .ack_push_pull_o  (ack_push_pull_o),
  .ack_open_drain_o (ack_open_drain_o),
  .boot_kind        (boot_kind)
);

// File: tb/boot_seq_test.sv
module boot_seq_test;
  localparam int BW = 14;
  localparam int PW = 14;
  localparam int NWORDS = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_a, mode_b, mode_d, pf2;
  logic bus_req = 1'b0, bdma_ack = 1'b0, host_we = 1'b0;
  logic [7:0] bdma_data = '0;
  logic [PW-1:0] host_addr = '0;
  logic flag2, bus_grant, bdma_req, pm_we, core_init, core_stall, core_release;
  logic start_ext, host_mode, mode_err, ack_pp, ack_od;
  logic [BW-1:0] bdma_addr;
  logic [PW-1:0] pm_addr, start_addr;
  logic [23:0] pm_wdata;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  boot_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_a_i(mode_a), .mode_b_i(mode_b),
    .mode_d_i(mode_d), .pf2_pin_i(pf2), .flag2_o(flag2), .bus_req_i(bus_req),
    .bus_grant_o(bus_grant), .bdma_req_o(bdma_req), .bdma_addr_o(bdma_addr),
    .bdma_ack_i(bdma_ack), .bdma_data_i(bdma_data), .pm_we_o(pm_we),
    .pm_addr_o(pm_addr), .pm_wdata_o(pm_wdata), .host_pm_we_i(host_we),
    .host_pm_addr_i(host_addr), .core_init_o(core_init), .core_stall_o(core_stall),
    .core_release_o(core_release), .start_addr_o(start_addr), .start_ext_o(start_ext),
    .host_mode_o(host_mode), .mode_err_o(mode_err), .ack_push_pull_o(ack_pp),
    .ack_open_drain_o(ack_od)
  );

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(int a);
    return 8'(a * 37 + 11);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int m = 0; m < 16; m++) begin
      int  cba;
      int  kind;   // 0 none, 1 byte, 2 host
      bit  hm, err, defer;
      cba = m & 7;
      hm  = (cba == 4) || (cba == 5);
      err = !(cba == 0 || cba == 2 || cba == 4 || cba == 5);
      kind = (cba == 0 || cba == 4) ? 1 : (cba == 5) ? 2 : 0;
      defer = (m == 0) || (m == 4) || (m == 13) || (m == 2) || (m == 10);

      @(negedge clk);
      rst_ni = 1'b0;
      mode_a = m[0]; mode_b = m[1]; pf2 = m[2]; mode_d = m[3];
      bus_req = defer; bdma_ack = 1'b0; host_we = 1'b0; host_addr = '0;
      repeat (3) @(negedge clk);
      // R1
      chk("R1", "core_init", core_init, 1);
      chk("R1", "stall", core_stall, 1);
      chk("R1", "release", core_release, 0);
      chk("R1", "flag2", flag2, 0);

      rst_ni = 1'b1;
      @(negedge clk);
      // R2 / R9
      chk("R2", $sformatf("host_mode m=%0d", m), host_mode, hm);
      chk("R2", $sformatf("mode_err m=%0d", m), mode_err, err);
      chk("R9", $sformatf("ack_pp m=%0d", m), ack_pp, hm && !m[3]);
      chk("R9", $sformatf("ack_od m=%0d", m), ack_od, hm && m[3]);

      if (kind == 0) begin
        // R4
        chk("R4", "release", core_release, 1);
        chk("R4", "start_ext", start_ext, 1);
        chk("R4", "start_addr", int'(start_addr), 0);
        chk("R4", "stall", core_stall, 0);
        bus_req = 1'b0;
        @(negedge clk);
        chk("R10", "release drop", core_release, 0);
      end else begin
        if (defer) begin
          // R8
          for (int i = 0; i < 4; i++) begin
            chk("R8", "bdma_req deferred", bdma_req, 0);
            chk("R8", "grant", bus_grant, 1);
            chk("R8", "stall", core_stall, 1);
            @(negedge clk);
          end
          bus_req = 1'b0;
          @(negedge clk);
        end
        if (kind == 1) begin
          int  widx = 0;
          bit  seen = 0;
          for (int cyc = 0; cyc < 2000 && !seen; cyc++) begin
            if (pm_we) begin
              // R5
              chk("R5", $sformatf("word %0d data", widx), int'(pm_wdata),
                  int'({mem_byte(3*widx), mem_byte(3*widx+1), mem_byte(3*widx+2)}));
              chk("R5", $sformatf("word %0d addr", widx), int'(pm_addr), widx);
              widx++;
            end
            if (core_release) begin
              // R6
              chk("R6", "words at release", widx, NWORDS);
              chk("R6", "start_ext", start_ext, 0);
              chk("R6", "start_addr", int'(start_addr), 0);
              seen = 1;
            end else if (!seen) begin
              if (core_stall != 1) chk("R6", "stall before release", core_stall, 1);
            end
            if (bus_req) chk("R8", "grant during load", bus_grant, 0);
            bus_req   = (m == 8) && cyc >= 20 && cyc < 26;
            bdma_ack  = bdma_req && (((cyc + m) % (1 + m % 3)) == 0);
            bdma_data = mem_byte(int'(bdma_addr));
            if (!seen) @(negedge clk);
          end
          chk("R6", "release seen", seen, 1);
          bdma_ack = 1'b0;
          bus_req  = 1'b0;
          @(negedge clk);
          for (int i = 0; i < 5; i++) begin
            chk("R10", "no second release", core_release, 0);
            chk("R6", "no extra word", pm_we, 0);
            @(negedge clk);
          end
        end else begin
          chk("R7", "no bdma in host boot", bdma_req, 0);
          host_we = 1'b1; host_addr = PW'(5);
          @(negedge clk);
          host_we = 1'b0;
          repeat (2) @(negedge clk);
          chk("R7", "release after addr 5", core_release, 0);
          chk("R7", "stall after addr 5", core_stall, 1);
          host_we = 1'b1; host_addr = '0;
          @(negedge clk);
          host_we = 1'b0;
          chk("R7", "release after addr 0", core_release, 1);
          chk("R7", "start_ext", start_ext, 0);
          chk("R7", "stall", core_stall, 0);
          @(negedge clk);
          chk("R10", "release drop", core_release, 0);
        end
      end

      // R3
      pf2 = ~m[2];
      @(negedge clk);
      chk("R3", "flag2 follows pin", flag2, !m[2]);
      chk("R3", "mode kept", host_mode, hm);
      chk("R3", "err kept", mode_err, err);
    end
    summary();
  end
endmodule